// File: doc/BRIEF.md
# Serial Registration-Number CRC-8 Engine

This block computes the 8-bit cyclic check over a 64-bit device registration number that arrives one bit per clock. The number is made of an 8-bit family code, a 48-bit serial number and an 8-bit check byte. Bits are qualified by a valid strobe and come least significant bit first, starting with the family code. The block exposes the running check value, a flag that goes high once the 56 data bits have been taken in, and a pass flag after all 64 bits when the residue is zero.

In generate mode only the 56 data bits are supplied. The block then assembles the complete 64-bit number with the computed check byte in its top eight bits. A synchronous clear restarts a run and samples the mode for that run. Line timing on the single-wire bus and search arbitration live elsewhere.

Top module: `romid_crc8`

## Requirements
- R1: After reset `crc_value` is 00h and `crc_ready`, `done` and `pass` are 0.
- R2: Each accepted bit updates the register with feedback f = bit XOR register bit 0. The register shifts right by one, and when f is 1 it is XORed with 8Ch (polynomial x^8+x^5+x^4+1, reflected). The register starts at 00h.
- R3: `crc_ready` is 0 until 56 bits have been accepted and then stays 1 until clear. At that point `crc_value` equals the check byte of the 56 bits.
- R4: In check mode `done` goes to 1 once 64 bits have been accepted. `pass` is 1 exactly when `done` is 1 and `crc_value` is 00h.
- R5: Valid bits presented after the run is complete (64 bits in check mode, 56 in generate mode) change neither `crc_value` nor `id_word`.
- R6: `id_word` bit i holds the i-th accepted bit, counting from 0.
- R7: In generate mode (`mode_gen`=1 sampled at clear) `done` rises after 56 bits. `id_word[63:56]` then equals the check byte, `id_word[55:0]` holds the data, and `pass` stays 0.
- R8: `clear` returns the bit count to 0 and `crc_value` to 00h, and the bit presented with `bit_valid` in the same cycle is dropped.
- R9: A cycle with `bit_valid` low changes no output.
- R10: A change of `mode_gen` has no effect until the next `clear`. Reset selects check mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous restart; samples `mode_gen` |
| mode_gen | input | 1 | 1 = generate mode, 0 = check mode |
| bit_valid | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Serial bit, LSB first |
| crc_value | output | 8 | Running check register |
| crc_ready | output | 1 | 56 data bits consumed |
| done | output | 1 | Run complete |
| pass | output | 1 | Check mode, 64 bits, zero residue |
| id_word | output | 64 | Captured (or generated) registration number |

## Verification
A restart and the arrival of a valid bit can fall in the same cycle. The bench provokes this by raising `clear` together with `bit_valid` and `bit_in`=1 in the middle of a run. It judges the outcome in two ways. The register must read 00h with `crc_ready` low right after that edge. A complete valid ID fed afterwards must then pass, which shows that the colliding bit was not counted. A second overlap is the last data bit completing the count in the same cycle as the check value becomes final. This is judged by sampling `crc_ready` after the 55th and after the 56th bit.

// File: rtl/romid_pkg.sv
// Shared definitions for the registration-number CRC engine.
// Assumes the field widths of a 64-bit device ID: 8 + 48 + 8.
package romid_pkg;
    localparam int FAM_W_D = 8;
    localparam int SER_W_D = 48;
    localparam int CRC_W_D = 8;
    localparam logic [7:0] POLY_REFL_D = 8'h8C;

    typedef enum logic {
        MODE_CHECK = 1'b0,
        MODE_GEN   = 1'b1
    } crc_mode_e;
endpackage

// File: rtl/crc8_serial.sv
// Bit-serial reflected CRC register.
// Assumes bits arrive LSB first; accept is already qualified by the caller.
module crc8_serial #(
    parameter int          CRC_W = 8,
    parameter logic [CRC_W-1:0] POLY  = 8'h8C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             accept,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_q
);
    logic             fb;
    logic [CRC_W-1:0] crc_next;

    // Next register value for one shifted-in bit.
    always_comb begin
        fb       = bit_in ^ crc_q[0];
        crc_next = {1'b0, crc_q[CRC_W-1:1]} ^ ({CRC_W{fb}} & POLY);
    end

    // Register update: reset/clear to zero, else shift on accept.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc_q <= '0;
        end else if (accept) begin
            crc_q <= crc_next;
        end
    end
endmodule

// File: rtl/bit_phase.sv
// Bit counter and run-mode latch.
// Assumes the run limit is 56 bits in generate mode and 64 in check mode.
module bit_phase #(
    parameter int DATA_BITS = 56,
    parameter int TOTAL     = 64,
    localparam int CNT_W    = $clog2(TOTAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             mode_gen,
    input  logic             bit_valid,
    output logic             accept,
    output logic [CNT_W-1:0] cnt_q,
    output logic             gen_q,
    output logic             ready,
    output logic             full
);
    localparam logic [CNT_W-1:0] DATA_LIM  = CNT_W'(DATA_BITS);
    localparam logic [CNT_W-1:0] TOTAL_LIM = CNT_W'(TOTAL);

    // Run limit and bit acceptance.
    always_comb begin
        full   = gen_q ? (cnt_q == DATA_LIM) : (cnt_q == TOTAL_LIM);
        ready  = (cnt_q >= DATA_LIM);
        accept = bit_valid && !full && !clear;
    end

    // Count accepted bits; restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Latch the run mode at reset (check) or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= romid_pkg::MODE_CHECK;
        end else if (clear) begin
            gen_q <= mode_gen;
        end
    end
endmodule

// File: rtl/id_capture.sv
// Assembles the serial bits into the registration-number word.
// Assumes idx is below TOTAL whenever accept is high.
module id_capture #(
    parameter int TOTAL = 64,
    localparam int IDX_W = $clog2(TOTAL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             accept,
    input  logic [IDX_W-1:0] idx,
    input  logic             bit_in,
    output logic [TOTAL-1:0] cap_q
);
    // Store each accepted bit at its arrival position.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cap_q <= '0;
        end else if (accept) begin
            cap_q[idx] <= bit_in;
        end
    end
endmodule

// File: rtl/romid_crc8.sv
// Top: serial CRC-8 checker/generator for a 64-bit registration number.
// Assumes LSB-first input starting with the family code; mode is sampled at clear.
module romid_crc8 #(
    parameter int FAM_W = romid_pkg::FAM_W_D,
    parameter int SER_W = romid_pkg::SER_W_D,
    parameter int CRC_W = romid_pkg::CRC_W_D,
    parameter logic [CRC_W-1:0] POLY = romid_pkg::POLY_REFL_D,
    localparam int DATA_BITS = FAM_W + SER_W,
    localparam int TOTAL     = DATA_BITS + CRC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             mode_gen,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_value,
    output logic             crc_ready,
    output logic             done,
    output logic             pass,
    output logic [TOTAL-1:0] id_word
);
    localparam int CNT_W = $clog2(TOTAL + 1);
    localparam int IDX_W = $clog2(TOTAL);

    logic             accept;
    logic [CNT_W-1:0] cnt_q;
    logic             gen_q;
    logic             full;
    logic [TOTAL-1:0] cap_q;

    bit_phase #(.DATA_BITS(DATA_BITS), .TOTAL(TOTAL)) u_phase (
        .clk(clk), .rst_n(rst_n), .clear(clear), .mode_gen(mode_gen),
        .bit_valid(bit_valid), .accept(accept), .cnt_q(cnt_q),
        .gen_q(gen_q), .ready(crc_ready), .full(full)
    );

    crc8_serial #(.CRC_W(CRC_W), .POLY(POLY)) u_crc (
        .clk(clk), .rst_n(rst_n), .clear(clear), .accept(accept),
        .bit_in(bit_in), .crc_q(crc_value)
    );

    id_capture #(.TOTAL(TOTAL)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear(clear), .accept(accept),
        .idx(cnt_q[IDX_W-1:0]), .bit_in(bit_in), .cap_q(cap_q)
    );

    // Output word and completion flags.
    always_comb begin
        done    = full;
        pass    = full && !gen_q && (crc_value == '0);
        id_word = gen_q ? {crc_value, cap_q[DATA_BITS-1:0]} : cap_q;
    end
endmodule

// File: rtl/romid_crc8_chk.sv
// Protocol checker for romid_crc8, attached by bind.
// Assumes only the top-level ports are visible.
module romid_crc8_chk #(
    parameter int CRC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             bit_valid,
    input logic [CRC_W-1:0] crc_value,
    input logic             crc_ready,
    input logic             done,
    input logic             pass
);
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc_value == '0 && !crc_ready && !done)); // R8
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_ready && !clear) |=> crc_ready); // R3
    AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (done && crc_value == '0)); // R4
    AST_DONE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clear) |=> ($stable(crc_value) && done)); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && !clear) |=> $stable(crc_value)); // R9
endmodule

bind romid_crc8 romid_crc8_chk #(.CRC_W(CRC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear(clear), .bit_valid(bit_valid),
    .crc_value(crc_value), .crc_ready(crc_ready), .done(done), .pass(pass)
);

// File: tb/tb_romid_crc8.sv
module tb_romid_crc8;
    logic        clk = 1'b0;
    logic        rst_n, clear, mode_gen, bit_valid, bit_in;
    logic [7:0]  crc_value;
    logic        crc_ready, done, pass;
    logic [63:0] id_word;
    int          errors = 0;
    int          checks = 0;
    bit          finished = 1'b0;

    romid_crc8 dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .mode_gen(mode_gen),
        .bit_valid(bit_valid), .bit_in(bit_in), .crc_value(crc_value),
        .crc_ready(crc_ready), .done(done), .pass(pass), .id_word(id_word)
    );

    always #4 clk = ~clk;

    // Vector table: 56-bit data, expected check byte (8'hxx -> use model).
    localparam logic [63:0] VEC [5] = '{
        64'hA2_0000_0001_B81C02,
        64'h00_0000_0000_000000,
        64'h00_FFFF_FFFF_FFFFFF,
        64'h00_1234_5678_9ABC01,
        64'h00_8000_0000_000028
    };

    function automatic logic [7:0] model_crc(input logic [63:0] v, input int n);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < n; i++) begin
            logic f = v[i] ^ c[0];
            c = {1'b0, c[7:1]} ^ (f ? 8'h8C : 8'h00);
        end
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        bit_valid = 1'b1; bit_in = b;
        @(negedge clk);
        bit_valid = 1'b0; bit_in = 1'b0;
    endtask

    task automatic feed(input logic [63:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic restart(input logic gen);
        clear = 1'b1; mode_gen = gen;
        @(negedge clk);
        clear = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] full_id;
        logic [7:0]  c;
        rst_n = 1'b0; clear = 1'b0; mode_gen = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(crc_value == 8'h00 && !crc_ready && !done && !pass, "R1",
            {crc_ready, done, pass, crc_value}, 64'h0);

        // Table walk in check mode: R2 R3 R4 R6
        for (int k = 0; k < 5; k++) begin
            c = model_crc(VEC[k], 56);
            if (k == 0) chk(c == 8'hA2, "R2 model anchor", c, 8'hA2);
            full_id = {c, VEC[k][55:0]};
            restart(1'b0);
            feed(full_id, 55);
            chk(!crc_ready, "R3 not ready at 55", crc_ready, 0);
            feed(full_id >> 55, 1);
            chk(crc_ready && crc_value == c && !done, "R2/R3 check byte",
                crc_value, c);
            feed(full_id >> 56, 8);
            chk(done && pass && crc_value == 8'h00, "R4 pass", {done, pass, crc_value}, 64'h300);
            chk(id_word == full_id, "R6 id capture", id_word, full_id);
        end

        // R4 corrupted check byte
        c = model_crc(VEC[3], 56);
        full_id = {c ^ 8'h10, VEC[3][55:0]};
        restart(1'b0);
        feed(full_id, 64);
        chk(done && !pass, "R4 bad id fails", {done, pass}, 64'h2);

        // R5 extra bits after done ignored
        c = crc_value;
        feed(64'hFFFF, 6);
        chk(crc_value == c && id_word == full_id && done, "R5 ignore extra",
            crc_value, c);

        // R7 generate mode
        restart(1'b1);
        feed(VEC[0], 56);
        chk(done && !pass && id_word == VEC[0], "R7 generate", id_word, VEC[0]);
        feed(64'hFF, 4);
        chk(id_word == VEC[0], "R5 gen extra ignored", id_word, VEC[0]);

        // R9 idle cycles change nothing
        restart(1'b0);
        feed(VEC[2], 20);
        c = crc_value;
        repeat (5) @(negedge clk);
        chk(crc_value == c && !crc_ready, "R9 idle hold", crc_value, c);

        // R8 clear collides with a valid bit
        clear = 1'b1; mode_gen = 1'b0; bit_valid = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        clear = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
        chk(crc_value == 8'h00 && !crc_ready, "R8 clear wins", crc_value, 0);
        c = model_crc(VEC[4], 56);
        feed({c, VEC[4][55:0]}, 64);
        chk(done && pass, "R8 bit dropped", {done, pass}, 64'h3);

        // R10 mode change mid-run ignored
        restart(1'b0);
        mode_gen = 1'b1;
        feed(VEC[0], 56);
        chk(!done, "R10 mode held", done, 0);
        // R10 reset selects check mode
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        mode_gen = 1'b1;
        feed(VEC[0], 56);
        chk(!done && crc_ready, "R10 reset check mode", done, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule